// File: doc/BRIEF.md
# Selection message validation sequencer

This block runs on the target side of a parallel peripheral bus. After the target has been selected while the initiator holds attention, the block takes the message-out bytes and checks them. The first byte is always an identify message. When tagged queueing or the SCSI-2 operating mode is enabled, that byte is followed by a two-byte queue tag message: a tag message code, then a free tag value.

Bytes arrive on a simple valid/ready stream, one byte per cycle at most. Each accepted byte is checked as it arrives. The sequence ends in one of two ways:
- It completes and gives a one-cycle done pulse.
- It halts and raises an interrupt that carries a two-bit reason code.

The captured identify byte, tag code and tag value are held on output registers until the next selection begins. A synchronous start pulse begins each new selection.

Top module: `selmsg_seq`

## Requirements
- R1: After synchronous active-low reset, `in_ready_o`, `done_o` and `irq_o` are 0, `irq_code_o` is 00, and all three captured fields are 0.
- R2: A `start_i` pulse clears the flags, the reason code and the captured fields on the next edge. `in_ready_o` is 1 from the following cycle until the sequence ends.
- R3: An identify byte with bit 7 equal to 0 halts the sequence. One cycle after the byte is accepted, `irq_o` is 1, `irq_code_o` is 01, `in_ready_o` is 0, and the byte is visible on `ident_o`.
- R4: Single-byte mode applies when both `tagq_en_i` and `mode2_en_i` are 0 at the moment the identify byte is accepted. In this mode, a valid identify byte accepted with `atn_i` low ends the sequence with `done_o` high for exactly the following cycle, and `in_ready_o` is 0 after that.
- R5: In single-byte mode, a valid identify byte accepted while `atn_i` is high aborts the sequence, with `irq_o` 1 and `irq_code_o` 11.
- R6: If either enable is 1 when the identify byte is accepted, the block stays ready and takes exactly three bytes. `done_o` pulses only after the third byte, whatever the level of `atn_i`.
- R7: The second byte of a three-byte sequence is accepted only if it is 0x20, 0x21 or 0x22. Any other value halts the sequence with `irq_o` 1 and `irq_code_o` 10, and that byte is captured on `tagmsg_o`.
- R8: The third byte is accepted for every value from 0x00 to 0xFF and is presented on `tagval_o`.
- R9: Captured fields, `irq_o` and `irq_code_o` hold their values until the next `start_i`.
- R10: `done_o` is never high in two consecutive cycles and is never high together with `irq_o`.
- R11: A byte offered while `in_ready_o` is 0 is ignored: no captured field or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new selection (pulse) |
| in_valid_i | input | 1 | Message byte offered |
| in_data_i | input | DATA_W | Message byte |
| in_ready_o | output | 1 | Block will take a byte this cycle |
| atn_i | input | 1 | Attention level from the bus |
| tagq_en_i | input | 1 | Tagged queueing enable |
| mode2_en_i | input | 1 | SCSI-2 mode enable |
| done_o | output | 1 | One-cycle completion pulse |
| irq_o | output | 1 | Halt interrupt, held until start |
| irq_code_o | output | 2 | Reason: 01 identify, 10 tag code, 11 attention abort |
| ident_o | output | DATA_W | Captured identify byte |
| tagmsg_o | output | DATA_W | Captured tag message code |
| tagval_o | output | DATA_W | Captured tag value |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, tag codes starting at 0x20 with three members, and the identify flag in bit 7. These values make every allowed tag code reachable, and they also reach the codes directly below and above the allowed set (0x1F and 0x23) as well as the tag-value extremes 0x00 and 0xFF. Both enable inputs are exercised on their own, so each of them separately selects the three-byte path. Attention is held high on the three-byte path to show that it is ignored there.

// File: rtl/selmsg_pkg.sv
package selmsg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ID,
      ST_TMSG,
      ST_TVAL,
      ST_DONE,
      ST_HALT
   } sel_state_e;

   localparam logic [1:0] RC_NONE      = 2'b00;
   localparam logic [1:0] RC_BAD_ID    = 2'b01;
   localparam logic [1:0] RC_BAD_TAG   = 2'b10;
   localparam logic [1:0] RC_ATN_ABORT = 2'b11;

endpackage

// File: rtl/selmsg_id_chk.sv
module selmsg_id_chk #(
   parameter int DATA_W      = 8,
   parameter int ID_FLAG_POS = 7
) (
   input  logic [DATA_W-1:0] byte_i,
   output logic              ok_o
);

   generate
      if (ID_FLAG_POS >= DATA_W) begin : g_bad_pos
         $error("selmsg_id_chk: ID_FLAG_POS outside byte");
      end
   endgenerate

   assign ok_o = byte_i[ID_FLAG_POS];

endmodule

// File: rtl/selmsg_tag_chk.sv
module selmsg_tag_chk #(
   parameter int DATA_W      = 8,
   parameter int TAG_BASE    = 32,
   parameter int TAG_COUNT   = 3,
   parameter bit MATCH_RANGE = 1'b0
) (
   input  logic [DATA_W-1:0] byte_i,
   output logic              ok_o
);

   localparam int TAG_LAST = TAG_BASE + TAG_COUNT - 1;

   generate
      if (TAG_COUNT < 1 || TAG_LAST >= (1 << DATA_W)) begin : g_bad_set
         $error("selmsg_tag_chk: tag code set does not fit the byte");
      end

      if (MATCH_RANGE) begin : g_range
         // one magnitude compare pair
         assign ok_o = (int'(byte_i) >= TAG_BASE) && (int'(byte_i) <= TAG_LAST);
      end else begin : g_each
         // one equality compare per allowed code
         logic [TAG_COUNT-1:0] hit;
         for (genvar k = 0; k < TAG_COUNT; k++) begin : g_code
            localparam logic [DATA_W-1:0] CODE = DATA_W'(TAG_BASE + k);
            assign hit[k] = (byte_i == CODE);
         end
         assign ok_o = |hit;
      end
   endgenerate

endmodule

// File: rtl/selmsg_capture.sv
module selmsg_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              ld_id_i,
   input  logic              ld_msg_i,
   input  logic              ld_val_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic [DATA_W-1:0] ident_o,
   output logic [DATA_W-1:0] tagmsg_o,
   output logic [DATA_W-1:0] tagval_o
);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         ident_o  <= '0;
         tagmsg_o <= '0;
         tagval_o <= '0;
      end else begin
         if (ld_id_i)  ident_o  <= byte_i;
         if (ld_msg_i) tagmsg_o <= byte_i;
         if (ld_val_i) tagval_o <= byte_i;
      end
   end

endmodule

// File: rtl/selmsg_fsm.sv
module selmsg_fsm
   import selmsg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       in_valid_i,
   input  logic       atn_i,
   input  logic       three_i,
   input  logic       id_ok_i,
   input  logic       tag_ok_i,
   output logic       ready_o,
   output logic       done_o,
   output logic       irq_o,
   output logic [1:0] code_o,
   output logic       ld_id_o,
   output logic       ld_msg_o,
   output logic       ld_val_o
);

   sel_state_e st;
   logic       take;

   assign ready_o  = (st == ST_ID) || (st == ST_TMSG) || (st == ST_TVAL);
   assign take     = in_valid_i && ready_o && !start_i;
   assign ld_id_o  = take && (st == ST_ID);
   assign ld_msg_o = take && (st == ST_TMSG);
   assign ld_val_o = take && (st == ST_TVAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         done_o <= 1'b0;
         irq_o  <= 1'b0;
         code_o <= RC_NONE;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            st     <= ST_ID;
            irq_o  <= 1'b0;
            code_o <= RC_NONE;
         end else if (take) begin
            case (st)
               ST_ID: begin
                  if (!id_ok_i) begin
                     irq_o  <= 1'b1;
                     code_o <= RC_BAD_ID;
                     st     <= ST_HALT;
                  end else if (three_i) begin
                     st <= ST_TMSG;
                  end else if (atn_i) begin
                     irq_o  <= 1'b1;
                     code_o <= RC_ATN_ABORT;
                     st     <= ST_HALT;
                  end else begin
                     done_o <= 1'b1;
                     st     <= ST_DONE;
                  end
               end
               ST_TMSG: begin
                  if (tag_ok_i) begin
                     st <= ST_TVAL;
                  end else begin
                     irq_o  <= 1'b1;
                     code_o <= RC_BAD_TAG;
                     st     <= ST_HALT;
                  end
               end
               ST_TVAL: begin
                  done_o <= 1'b1;
                  st     <= ST_DONE;
               end
               default: st <= st;
            endcase
         end
      end
   end

endmodule

// File: rtl/selmsg_seq.sv
module selmsg_seq #(
   parameter int DATA_W      = 8,
   parameter int ID_FLAG_POS = 7,
   parameter int TAG_BASE    = 32,
   parameter int TAG_COUNT   = 3,
   parameter bit MATCH_RANGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] in_data_i,
   output logic              in_ready_o,
   input  logic              atn_i,
   input  logic              tagq_en_i,
   input  logic              mode2_en_i,
   output logic              done_o,
   output logic              irq_o,
   output logic [1:0]        irq_code_o,
   output logic [DATA_W-1:0] ident_o,
   output logic [DATA_W-1:0] tagmsg_o,
   output logic [DATA_W-1:0] tagval_o
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("selmsg_seq: DATA_W must be at least 8");
      end
   endgenerate

   logic id_ok, tag_ok, three;
   logic ld_id, ld_msg, ld_val;

   assign three = tagq_en_i || mode2_en_i;

   selmsg_id_chk #(
      .DATA_W(DATA_W), .ID_FLAG_POS(ID_FLAG_POS)
   ) u_id (
      .byte_i(in_data_i), .ok_o(id_ok)
   );

   selmsg_tag_chk #(
      .DATA_W(DATA_W), .TAG_BASE(TAG_BASE),
      .TAG_COUNT(TAG_COUNT), .MATCH_RANGE(MATCH_RANGE)
   ) u_tag (
      .byte_i(in_data_i), .ok_o(tag_ok)
   );

   selmsg_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .in_valid_i(in_valid_i), .atn_i(atn_i), .three_i(three),
      .id_ok_i(id_ok), .tag_ok_i(tag_ok),
      .ready_o(in_ready_o), .done_o(done_o), .irq_o(irq_o),
      .code_o(irq_code_o),
      .ld_id_o(ld_id), .ld_msg_o(ld_msg), .ld_val_o(ld_val)
   );

   selmsg_capture #(
      .DATA_W(DATA_W)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i),
      .ld_id_i(ld_id), .ld_msg_i(ld_msg), .ld_val_i(ld_val),
      .byte_i(in_data_i),
      .ident_o(ident_o), .tagmsg_o(tagmsg_o), .tagval_o(tagval_o)
   );

endmodule

// File: rtl/selmsg_seq_chk.sv
module selmsg_seq_chk #(
   parameter int DATA_W      = 8,
   parameter int ID_FLAG_POS = 7,
   parameter int TAG_BASE    = 32,
   parameter int TAG_COUNT   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              in_valid_i,
   input logic              in_ready_o,
   input logic              done_o,
   input logic              irq_o,
   input logic [1:0]        irq_code_o,
   input logic [DATA_W-1:0] ident_o,
   input logic [DATA_W-1:0] tagmsg_o,
   input logic [DATA_W-1:0] tagval_o
);

   // R10
   done_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && irq_o));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R3
   bad_id_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && irq_code_o == 2'b01) |-> !ident_o[ID_FLAG_POS]);

   // R7
   bad_tag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && irq_code_o == 2'b10) |->
         !((int'(tagmsg_o) >= TAG_BASE) && (int'(tagmsg_o) < TAG_BASE + TAG_COUNT)));

   // R2
   start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (in_ready_o && !irq_o && !done_o));

   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !start_i) |=> (irq_o && $stable(irq_code_o)));

   // R9
   field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !(in_valid_i && in_ready_o)) |=>
         ($stable(ident_o) && $stable(tagmsg_o) && $stable(tagval_o)));

   // R11
   ended_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o || done_o) |-> !in_ready_o);

endmodule

bind selmsg_seq selmsg_seq_chk #(
   .DATA_W(DATA_W), .ID_FLAG_POS(ID_FLAG_POS),
   .TAG_BASE(TAG_BASE), .TAG_COUNT(TAG_COUNT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
   .in_ready_o(in_ready_o), .done_o(done_o), .irq_o(irq_o),
   .irq_code_o(irq_code_o), .ident_o(ident_o), .tagmsg_o(tagmsg_o),
   .tagval_o(tagval_o)
);

// File: tb/selmsg_seq_tb.sv
`timescale 1ns/1ps
module selmsg_seq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       in_valid_i = 1'b0;
   logic [7:0] in_data_i = 8'h00;
   logic       atn_i = 1'b0;
   logic       tagq_en_i = 1'b0;
   logic       mode2_en_i = 1'b0;
   logic       in_ready_o, done_o, irq_o;
   logic [1:0] irq_code_o;
   logic [7:0] ident_o, tagmsg_o, tagval_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   selmsg_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
      .atn_i(atn_i), .tagq_en_i(tagq_en_i), .mode2_en_i(mode2_en_i),
      .done_o(done_o), .irq_o(irq_o), .irq_code_o(irq_code_o),
      .ident_o(ident_o), .tagmsg_o(tagmsg_o), .tagval_o(tagval_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // all tasks begin and end just after a falling edge
   task automatic do_start();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic put(input logic [7:0] b);
      in_valid_i = 1'b1;
      in_data_i  = b;
      @(negedge clk);
      in_valid_i = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 ready", in_ready_o, 0);
      check("R1 done", done_o, 0);
      check("R1 irq", irq_o, 0);
      check("R1 code", irq_code_o, 0);
      check("R1 fields", {ident_o, tagmsg_o, tagval_o}, 0);
   endtask

   task automatic t_ignore_idle();
      put(8'h81);
      check("R11 ident idle", ident_o, 0);
      check("R11 done idle", done_o, 0);
   endtask

   task automatic t_bad_id();
      do_start();
      check("R2 ready after start", in_ready_o, 1);
      put(8'h05);
      check("R3 irq", irq_o, 1);
      check("R3 code", irq_code_o, 1);
      check("R3 ident", ident_o, 8'h05);
      check("R3 ready", in_ready_o, 0);
   endtask

   task automatic t_hold();
      in_valid_i = 1'b1;
      in_data_i  = 8'h99;
      repeat (4) @(negedge clk);
      in_valid_i = 1'b0;
      check("R11 ident kept", ident_o, 8'h05);
      check("R9 irq kept", irq_o, 1);
      check("R9 code kept", irq_code_o, 1);
   endtask

   task automatic t_single_ok();
      tagq_en_i = 0; mode2_en_i = 0; atn_i = 0;
      do_start();
      check("R2 irq cleared", irq_o, 0);
      check("R2 code cleared", irq_code_o, 0);
      check("R2 ident cleared", ident_o, 0);
      put(8'hC0);
      check("R4 done", done_o, 1);
      check("R4 ident", ident_o, 8'hC0);
      check("R4 ready", in_ready_o, 0);
      @(negedge clk);
      check("R10 done one cycle", done_o, 0);
      check("R4 no irq", irq_o, 0);
   endtask

   task automatic t_single_atn();
      atn_i = 1;
      do_start();
      put(8'h80);
      check("R5 irq", irq_o, 1);
      check("R5 code", irq_code_o, 3);
      check("R5 done", done_o, 0);
      atn_i = 0;
   endtask

   task automatic t_three(input bit tq, input bit m2,
                          input logic [7:0] code, input logic [7:0] val);
      tagq_en_i = tq; mode2_en_i = m2; atn_i = 1;
      do_start();
      put(8'h81);
      check("R6 ready after id", in_ready_o, 1);
      check("R6 no done after id", done_o, 0);
      check("R6 no irq after id", irq_o, 0);
      put(code);
      check("R7 ready after code", in_ready_o, 1);
      check("R7 no irq for code", irq_o, 0);
      put(val);
      check("R6 done after third", done_o, 1);
      check("R8 tag value", tagval_o, val);
      check("R7 tag code", tagmsg_o, code);
      check("R6 ident", ident_o, 8'h81);
      @(negedge clk);
      check("R10 done one cycle", done_o, 0);
      tagq_en_i = 0; mode2_en_i = 0; atn_i = 0;
   endtask

   task automatic t_bad_tag(input logic [7:0] code);
      mode2_en_i = 1;
      do_start();
      put(8'hFF);
      put(code);
      check("R7 irq bad code", irq_o, 1);
      check("R7 reason bad code", irq_code_o, 2);
      check("R7 code captured", tagmsg_o, code);
      check("R7 ready", in_ready_o, 0);
      mode2_en_i = 0;
   endtask

   task automatic t_restart_mid();
      tagq_en_i = 1;
      do_start();
      put(8'h82);
      do_start();
      check("R2 restart ident cleared", ident_o, 0);
      check("R2 restart ready", in_ready_o, 1);
      put(8'h83);
      put(8'h22);
      put(8'h00);
      check("R8 tag zero", tagval_o, 8'h00);
      check("R6 done after restart", done_o, 1);
      tagq_en_i = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ignore_idle();
      t_bad_id();
      t_hold();
      t_single_ok();
      t_single_atn();
      t_three(1'b1, 1'b0, 8'h20, 8'h00);
      t_three(1'b0, 1'b1, 8'h21, 8'hFF);
      t_three(1'b1, 1'b1, 8'h22, 8'h5A);
      t_bad_tag(8'h23);
      t_bad_tag(8'h1F);
      t_restart_mid();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule